// File: doc/BRIEF.md
# Relocatable Configuration Register Window

This block is the control register file of a memory cartridge, seen by the host CPU as a small window of memory-mapped bytes. The window occupies 64 bytes at one of four base addresses, chosen by two bits of the main control byte. The window can also be withdrawn from the address map. It holds the main control byte and a mirror of it, a 23-bit flash address assembled from three byte registers, and a flash configuration byte. It also offers a data port that turns each access into a read or write strobe towards the flash device, at the assembled address.

The block also holds the mapping registers: a 64 KB block selector and four banks of six configuration bytes each. It supplies their active values to the cartridge's address translation logic. Writes to the mapping registers can either take effect at once or be staged in a shadow copy. A staged copy is committed in one clock edge when a chosen trigger is seen on the bus. The trigger is either an opcode fetch from address 0000h or a read of address 4000h.

Top module: `cfg_window`

## Requirements
- R1: After reset the main control byte and its mirror read 20h, the block selector 00h, the flash configuration 02h and the flash address 0. Each bank's six bytes are, in field order: mask F8h, select 50h, initial bank 00h, mode (85h for bank 0, 00h for the others), page mask 03h, base 40h.
- R2: Main control bits 6:5 select the window base: 00 gives 0F80h, 01 gives 4F80h, 10 gives 8F80h and 11 gives CF80h. The register offset is address bits 5:0. Accesses outside the selected window do not reach the registers.
- R3: A write to offset 00h or 1Fh loads the same byte into both the main control byte and its mirror.
- R4: Offsets 01h, 02h and 03h load flash address bits 7:0, 15:8 and 22:16. Bit 7 of the byte written to 03h is dropped.
- R5: A read at offset 04h pulses the flash read strobe in the same cycle and returns the flash byte on the read data port with the drive flag set. A write at 04h pulses the flash write strobe with the written byte. Reads of any other register offset are not driven.
- R6: With main control bit 7 set, the window ignores all writes and drives no read data.
- R7: With main control bit 0 set, the registers ignore writes. A read at offsets 00h–2Fh of the window pulses the flash read strobe at address {block selector bits 6:0, CPU address}, and the flash byte is returned.
- R8: Offsets 30h–3Fh are not decoded: writes there change no register.
- R9: With main control bit 3 clear, a write to offsets 05h–1Dh shows on the active outputs one clock later. Offset 05h is the block selector, and offset 06h+6·b+f is field f of bank b.
- R10: With main control bit 3 set, writes to offsets 05h–1Dh leave the active outputs unchanged until a trigger.
- R11: With main control bit 2 clear, only an opcode fetch from 0000h commits staged values. With bit 2 set, only a read of 4000h commits them. Any other access does not commit.
- R12: On a trigger, all staged mapping bytes become active on the same clock edge.
- R13: Offset 20h loads the flash configuration byte. Offsets 1Eh and 21h–2Fh change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| m1_i | input | 1 | The current read is an opcode fetch |
| rdata_o | output | 8 | Read data returned to the CPU |
| rdata_en_o | output | 1 | The block drives rdata_o this cycle |
| main_o | output | 8 | Main control byte |
| copy_o | output | 8 | Mirror of the main control byte |
| fcfg_o | output | 8 | Flash configuration byte |
| fl_addr_o | output | 23 | Flash address |
| fl_wdata_o | output | 8 | Flash write data |
| fl_rd_o | output | 1 | Flash read strobe |
| fl_wr_o | output | 1 | Flash write strobe |
| fl_rdata_i | input | 8 | Flash read data |
| blk_o | output | 8 | Active 64 KB block selector |
| bank_o | output | 192 | Active bank bytes, byte 6·b+f at bits 8·(6·b+f) upward |

## Verification
A wrong window decode shows one clock after the write: either the addressed register does not change, or a register that should hold its value changes. A pending flag or shadow copy that is out of step shows on blk_o and bank_o in the cycle after a trigger access. The symptom is either an active value that stays stale, or one that changes without a trigger. Hiding and flash pass-through errors show combinationally on fl_rd_o, fl_addr_o and rdata_en_o during the read strobe itself.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;
  localparam int unsigned BANK_FIELDS  = 6;
  localparam int unsigned WIN_MID      = 'h3E;    // address bits 13:6 of every window base
  localparam int unsigned TRIG_RD_ADDR = 'h4000;
  localparam logic [5:0]  OFF_MAIN  = 6'h00;
  localparam logic [5:0]  OFF_ADR   = 6'h01;
  localparam logic [5:0]  OFF_DATA  = 6'h04;
  localparam logic [5:0]  OFF_MAP   = 6'h05;
  localparam logic [5:0]  OFF_COPY  = 6'h1F;
  localparam logic [5:0]  OFF_FCFG  = 6'h20;
  localparam logic [5:0]  OFF_LIMIT = 6'h30;
  localparam logic [7:0]  RST_MAIN  = 8'h20;
  localparam logic [7:0]  RST_FCFG  = 8'h02;

  // reset value of mapping byte idx (0 = block selector, then banks)
  function automatic logic [7:0] map_rst(input int unsigned idx);
    int unsigned f;
    if (idx == 0) return 8'h00;
    f = (idx - 1) % BANK_FIELDS;
    case (f)
      0: return 8'hF8;
      1: return 8'h50;
      2: return 8'h00;
      3: return (idx - 1 < BANK_FIELDS) ? 8'h85 : 8'h00;
      4: return 8'h03;
      default: return 8'h40;
    endcase
  endfunction
endpackage

// File: rtl/cfg_win_decode.sv
module cfg_win_decode
  import cfg_window_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              m1_i,
  input  logic [1:0]        base_i,
  input  logic              hide_i,
  input  logic              pass_i,
  input  logic              trig_sel_i,
  output logic [5:0]        off_o,
  output logic              reg_wr_o,
  output logic              port_rd_o,
  output logic              port_wr_o,
  output logic              pass_rd_o,
  output logic              trig_o
);
  localparam logic [ADDR_W-9:0] MID     = (ADDR_W-8)'(WIN_MID);
  localparam logic [ADDR_W-1:0] TRIG_RD = ADDR_W'(TRIG_RD_ADDR);

  logic in_win;
  logic visible;

  assign off_o   = addr_i[5:0];
  assign in_win  = (addr_i[ADDR_W-1 -: 2] == base_i) &&
                   (addr_i[ADDR_W-3:6] == MID) && (off_o < OFF_LIMIT);
  assign visible = !hide_i && !pass_i;

  assign reg_wr_o  = wr_i && in_win && visible;
  assign port_wr_o = reg_wr_o && (off_o == OFF_DATA);
  assign port_rd_o = rd_i && in_win && visible && (off_o == OFF_DATA);
  assign pass_rd_o = rd_i && in_win && pass_i;

  assign trig_o = rd_i && (trig_sel_i ? (addr_i == TRIG_RD)
                                      : (m1_i && (addr_i == '0)));
endmodule

// File: rtl/cfg_main_regs.sv
module cfg_main_regs
  import cfg_window_pkg::*;
#(
  parameter int unsigned FL_ADDR_W = 23
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [5:0]           off_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           main_o,
  output logic [7:0]           copy_o,
  output logic [7:0]           fcfg_o,
  output logic [FL_ADDR_W-1:0] fladr_o
);
  logic [7:0] main_q, copy_q, fcfg_q;
  logic [FL_ADDR_W-1:0] fladr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= RST_MAIN;
      copy_q <= RST_MAIN;
      fcfg_q <= RST_FCFG;
    end else if (we_i) begin
      if (off_i == OFF_MAIN || off_i == OFF_COPY) begin
        main_q <= wdata_i;
        copy_q <= wdata_i;
      end
      if (off_i == OFF_FCFG) fcfg_q <= wdata_i;
    end
  end

  // one flop per flash address bit, loaded from its byte register offset
  for (genvar b = 0; b < FL_ADDR_W; b++) begin : g_adr
    localparam logic [5:0] BOFF = 6'(OFF_ADR + 6'(b / 8));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         fladr_q[b] <= 1'b0;
      else if (we_i && off_i == BOFF)      fladr_q[b] <= wdata_i[b % 8];
    end
  end

  assign main_o  = main_q;
  assign copy_o  = copy_q;
  assign fcfg_o  = fcfg_q;
  assign fladr_o = fladr_q;

  // R3: both main offsets load main and mirror together
  a_r3_main_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (off_i == OFF_MAIN || off_i == OFF_COPY)) |=>
      (main_o == $past(wdata_i) && copy_o == $past(wdata_i)));
endmodule

// File: rtl/cfg_map_regs.sv
module cfg_map_regs
  import cfg_window_pkg::*;
#(
  parameter int unsigned MAP_N = 25
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [5:0]         off_i,
  input  logic [7:0]         wdata_i,
  input  logic               delay_i,
  input  logic               trig_i,
  output logic [MAP_N*8-1:0] act_o
);
  localparam int unsigned IDX_W = $clog2(MAP_N);
  localparam logic [5:0]  MAP_END = 6'(OFF_MAP + 6'(MAP_N));

  logic [7:0] shd_q [MAP_N];
  logic [7:0] act_q [MAP_N];
  logic [MAP_N*8-1:0] shd_flat;
  logic [IDX_W-1:0] idx;
  logic map_we;
  logic pend_q;

  assign map_we = we_i && (off_i >= OFF_MAP) && (off_i < MAP_END);
  assign idx    = IDX_W'(off_i - OFF_MAP);

  for (genvar g = 0; g < MAP_N; g++) begin : g_map
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_q[g] <= map_rst(g);
        act_q[g] <= map_rst(g);
      end else if (map_we && idx == IDX_W'(g)) begin
        shd_q[g] <= wdata_i;
        if (!delay_i) act_q[g] <= wdata_i;
      end else if (trig_i && pend_q) begin
        act_q[g] <= shd_q[g];
      end
    end
    assign act_o[g*8 +: 8]    = act_q[g];
    assign shd_flat[g*8 +: 8] = shd_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pend_q <= 1'b0;
    else if (map_we && delay_i)   pend_q <= 1'b1;
    else if (trig_i)              pend_q <= 1'b0;
  end

  // R9: undelayed write visible next cycle
  a_r9_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_we && !delay_i) |=> (act_q[$past(idx)] == $past(wdata_i)));
  // R10: delayed write leaves active values alone
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_we && delay_i) |=> $stable(act_o));
  // R12: trigger copies every staged byte in one edge
  a_r12_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && pend_q) |=> (act_o == $past(shd_flat) && !pend_q));
endmodule

// File: rtl/cfg_window.sv
module cfg_window
  import cfg_window_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned FL_ADDR_W = 23,
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [7:0]                          wdata_i,
  input  logic                                wr_i,
  input  logic                                rd_i,
  input  logic                                m1_i,
  output logic [7:0]                          rdata_o,
  output logic                                rdata_en_o,
  output logic [7:0]                          main_o,
  output logic [7:0]                          copy_o,
  output logic [7:0]                          fcfg_o,
  output logic [FL_ADDR_W-1:0]                fl_addr_o,
  output logic [7:0]                          fl_wdata_o,
  output logic                                fl_rd_o,
  output logic                                fl_wr_o,
  input  logic [7:0]                          fl_rdata_i,
  output logic [7:0]                          blk_o,
  output logic [NUM_BANKS*BANK_FIELDS*8-1:0]  bank_o
);
  localparam int unsigned MAP_N    = 1 + NUM_BANKS * BANK_FIELDS;
  localparam int unsigned BLK_BITS = FL_ADDR_W - ADDR_W;

  logic [5:0] off;
  logic reg_wr, port_rd, port_wr, pass_rd, trig;
  logic [FL_ADDR_W-1:0] fladr;
  logic [MAP_N*8-1:0] act;

  cfg_win_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i), .m1_i(m1_i),
    .base_i(main_o[6:5]), .hide_i(main_o[7]), .pass_i(main_o[0]),
    .trig_sel_i(main_o[2]),
    .off_o(off), .reg_wr_o(reg_wr), .port_rd_o(port_rd),
    .port_wr_o(port_wr), .pass_rd_o(pass_rd), .trig_o(trig)
  );

  cfg_main_regs #(.FL_ADDR_W(FL_ADDR_W)) u_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_wr), .off_i(off),
    .wdata_i(wdata_i), .main_o(main_o), .copy_o(copy_o),
    .fcfg_o(fcfg_o), .fladr_o(fladr)
  );

  cfg_map_regs #(.MAP_N(MAP_N)) u_map (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_wr), .off_i(off),
    .wdata_i(wdata_i), .delay_i(main_o[3]), .trig_i(trig), .act_o(act)
  );

  assign blk_o  = act[7:0];
  assign bank_o = act[MAP_N*8-1:8];

  // pass-through reads address the active 64 KB block
  assign fl_addr_o  = pass_rd ? {blk_o[BLK_BITS-1:0], addr_i} : fladr;
  assign fl_rd_o    = port_rd || pass_rd;
  assign fl_wr_o    = port_wr;
  assign fl_wdata_o = wdata_i;
  assign rdata_en_o = fl_rd_o;
  assign rdata_o    = fl_rd_o ? fl_rdata_i : 8'h00;

  always_comb begin
    if (rst_ni) begin
      a_r7_excl: assert ($onehot0({port_rd, pass_rd, port_wr}));
    end
  end

  // R6: hidden window keeps all registers
  a_r6_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && main_o[7]) |=> ($stable(main_o) && $stable(act) && $stable(fladr)));
  // R8: offsets 30h-3Fh reach no register
  a_r8_undecoded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[5:0] >= OFF_LIMIT) |=>
      ($stable(main_o) && $stable(fcfg_o) && $stable(fladr) && $stable(act)));
endmodule

// File: tb/cfg_window_tb_top.sv
module cfg_window_tb_top;
  localparam int NV = 32;
  localparam int BW = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic wr = 1'b0, rd = 1'b0, m1 = 1'b0;
  logic [7:0] fl_rdata = 8'h5A;
  logic [7:0] rdata, main_v, copy_v, fcfg_v, fl_wdata, blk;
  logic rdata_en, fl_rd, fl_wr;
  logic [22:0] fl_addr;
  logic [BW-1:0] bank;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_window dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .m1_i(m1), .rdata_o(rdata), .rdata_en_o(rdata_en),
    .main_o(main_v), .copy_o(copy_v), .fcfg_o(fcfg_v), .fl_addr_o(fl_addr),
    .fl_wdata_o(fl_wdata), .fl_rd_o(fl_rd), .fl_wr_o(fl_wr),
    .fl_rdata_i(fl_rdata), .blk_o(blk), .bank_o(bank)
  );

  // {req[4], op[2] (0 wr,1 rd,2 fetch,3 idle), addr[16], data[8], sel[8], exp[24]}
  // sel: 01 main, 02 copy, 03 flash addr, 04 block, 05 flash cfg, 40h+n bank byte n
  localparam logic [61:0] VEC [NV] = '{
    {4'd4, 2'd0,16'h4F81,8'hAB,8'h03,24'h0000AB},  // R4 low byte
    {4'd4, 2'd0,16'h4F82,8'hCD,8'h03,24'h00CDAB},  // R4 mid byte
    {4'd4, 2'd0,16'h4F83,8'hFF,8'h03,24'h7FCDAB},  // R4 high byte, bit 7 dropped
    {4'd9, 2'd0,16'h4F85,8'h12,8'h04,24'h000012},  // R9 block selector
    {4'd9, 2'd0,16'h4F86,8'hE0,8'h40,24'h0000E0},  // R9 bank0 mask
    {4'd9, 2'd0,16'h4F9D,8'h77,8'h57,24'h000077},  // R9 bank3 base
    {4'd3, 2'd0,16'h4F9F,8'h40,8'h01,24'h000040},  // R3 write via mirror offset
    {4'd3, 2'd3,16'h1234,8'h00,8'h02,24'h000040},  // R3 mirror follows
    {4'd2, 2'd0,16'h4F85,8'h99,8'h04,24'h000012},  // R2 old base dead
    {4'd2, 2'd0,16'h8F85,8'h34,8'h04,24'h000034},  // R2 base 8F80
    {4'd3, 2'd0,16'h8F80,8'h60,8'h02,24'h000060},  // R3 main offset sets mirror
    {4'd2, 2'd0,16'hCF80,8'h00,8'h01,24'h000000},  // R2 base CF80, back to 0F80
    {4'd13,2'd0,16'h0FA0,8'h05,8'h05,24'h000005},  // R13 flash cfg
    {4'd13,2'd0,16'h0FA1,8'h55,8'h05,24'h000005},  // R13 offset 21h ignored
    {4'd13,2'd0,16'h0F9E,8'h55,8'h57,24'h000077},  // R13 offset 1Eh ignored
    {4'd8, 2'd0,16'h0FB0,8'h11,8'h4A,24'h000003},  // R8 offset 30h no alias
    {4'd8, 2'd0,16'h0FB0,8'h11,8'h01,24'h000000},  // R8 main untouched
    {4'd10,2'd0,16'h0F80,8'h08,8'h01,24'h000008},  // R10 enable delay, fetch trigger
    {4'd10,2'd0,16'h0F85,8'h56,8'h04,24'h000034},  // R10 block held
    {4'd10,2'd0,16'h0F86,8'hA1,8'h40,24'h0000E0},  // R10 bank held
    {4'd11,2'd1,16'h4000,8'h00,8'h04,24'h000034},  // R11 read 4000h not a trigger
    {4'd11,2'd2,16'h0001,8'h00,8'h04,24'h000034},  // R11 fetch elsewhere
    {4'd11,2'd1,16'h0000,8'h00,8'h04,24'h000034},  // R11 plain read of 0000h
    {4'd11,2'd2,16'h0000,8'h00,8'h04,24'h000056},  // R11 fetch 0000h commits
    {4'd12,2'd3,16'h1234,8'h00,8'h40,24'h0000A1},  // R12 bank committed too
    {4'd11,2'd0,16'h0F80,8'h0C,8'h01,24'h00000C},  // R11 select read trigger
    {4'd10,2'd0,16'h0F85,8'h78,8'h04,24'h000056},  // R10 held again
    {4'd11,2'd2,16'h0000,8'h00,8'h04,24'h000056},  // R11 fetch not a trigger now
    {4'd11,2'd1,16'h4000,8'h00,8'h04,24'h000078},  // R11 read 4000h commits
    {4'd6, 2'd0,16'h0F80,8'h80,8'h01,24'h000080},  // R6 hide
    {4'd6, 2'd0,16'h0F80,8'h00,8'h01,24'h000080},  // R6 main write ignored
    {4'd6, 2'd0,16'h0F85,8'h11,8'h04,24'h000078}   // R6 map write ignored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] obs(input logic [7:0] sel);
    case (sel)
      8'h01: return {24'h0, main_v};
      8'h02: return {24'h0, copy_v};
      8'h03: return {9'h0, fl_addr};
      8'h04: return {24'h0, blk};
      8'h05: return {24'h0, fcfg_v};
      default: return {24'h0, bank[(int'(sel) - 'h40) * 8 +: 8]};
    endcase
  endfunction

  task automatic drive(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    wr = (op == 2'd0);
    rd = (op == 2'd1) || (op == 2'd2);
    m1 = (op == 2'd2);
  endtask

  task automatic idle;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; m1 = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][57:56], VEC[i][55:40], VEC[i][39:32]);
      idle();
      chk($sformatf("R%0d vec%0d", VEC[i][61:58], i), obs(VEC[i][31:24]), {8'h0, VEC[i][23:0]});
    end

    // R6: hidden window drives no read
    drive(2'd1, 16'h0F84, 8'h00);
    #2 chk("R6 hidden read strobe", {31'h0, fl_rd}, 32'h0);
    chk("R6 hidden read drive", {31'h0, rdata_en}, 32'h0);
    idle();

    // R1: reset values
    do_reset();
    #2;
    chk("R1 main", {24'h0, main_v}, 32'h20);
    chk("R1 copy", {24'h0, copy_v}, 32'h20);
    chk("R1 block", {24'h0, blk}, 32'h00);
    chk("R1 fcfg", {24'h0, fcfg_v}, 32'h02);
    chk("R1 flash addr", {9'h0, fl_addr}, 32'h0);
    for (int b = 0; b < 4; b++) begin
      for (int f = 0; f < 6; f++) begin
        logic [7:0] e;
        case (f)
          0: e = 8'hF8;
          1: e = 8'h50;
          2: e = 8'h00;
          3: e = (b == 0) ? 8'h85 : 8'h00;
          4: e = 8'h03;
          default: e = 8'h40;
        endcase
        chk($sformatf("R1 bank%0d field%0d", b, f), {24'h0, bank[(b*6+f)*8 +: 8]}, {24'h0, e});
      end
    end

    // R5: data port
    drive(2'd0, 16'h4F81, 8'h10); idle();
    drive(2'd0, 16'h4F82, 8'h20); idle();
    drive(2'd0, 16'h4F83, 8'h30); idle();
    drive(2'd1, 16'h4F84, 8'h00);
    #2 chk("R5 read strobe", {31'h0, fl_rd}, 32'h1);
    chk("R5 read data", {23'h0, rdata_en, rdata}, 32'h15A);
    chk("R5 read addr", {9'h0, fl_addr}, 32'h302010);
    idle();
    drive(2'd0, 16'h4F84, 8'hC3);
    #2 chk("R5 write strobe", {23'h0, fl_wr, fl_wdata}, 32'h1C3);
    idle();
    drive(2'd1, 16'h4F81, 8'h00);
    #2 chk("R5 write-only reg not driven", {31'h0, rdata_en}, 32'h0);
    idle();

    // R7: flash pass-through
    drive(2'd0, 16'h4F85, 8'h03); idle();
    drive(2'd0, 16'h4F80, 8'h21); idle();
    chk("R7 main set", {24'h0, main_v}, 32'h21);
    drive(2'd1, 16'h4F84, 8'h00);
    #2 chk("R7 pass strobe", {31'h0, fl_rd}, 32'h1);
    chk("R7 pass addr", {9'h0, fl_addr}, 32'h034F84);
    chk("R7 pass data", {23'h0, rdata_en, rdata}, 32'h15A);
    idle();
    drive(2'd0, 16'h4F80, 8'h00); idle();
    chk("R7 write ignored", {24'h0, main_v}, 32'h21);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule